// File: doc/BRIEF.md
# E1 Receive Frame Slip Buffer

The block is an elastic store between two clock domains. On one side is the recovered receive line clock, which delivers serial E1 payload with a frame-start marker. On the other side is the terminal's 2.048 MHz system bit clock, which reads that payload out as a continuous serial stream. Data moves through the store in whole 256-bit frames, and the store holds two of them. The two clocks drift against each other. When the line side runs ahead, a complete arriving frame is dropped. When the system side runs ahead, the frame it has just sent is sent again. Each slip is reported through sticky status flags that clear when they are read.

On the system side, a direction control selects how frame timing is set. In generate mode, the block drives a one-bit-wide frame sync pulse on the last bit of every outgoing frame. In follow mode, the block takes a frame sync pulse from the terminal and starts a new outgoing frame on the next bit. The block also keeps a 16-frame multiframe count and pulses a multiframe sync on the last bit of the multiframe's second frame (index 1). In follow mode, the terminal can clear that count to zero by asserting an alignment input together with its frame sync pulse.

Top module: `e1_slip_buffer`

## Requirements
- R1: When a line frame completes while both storage slots hold unread frames, that whole frame is dropped. The output sequence then skips exactly one frame, and status bit 0 (full) is set.
- R2: When an output frame boundary arrives and no unread frame is stored, the frame just sent is sent again whole, and status bit 1 (empty) is set. Empty is never set without such a repeat.
- R3: Status bit 2 (slip) is set on every discard and every repeat. It is therefore high exactly when bit 0 or bit 1 is high.
- R4: Status bits are sticky. A cycle with `st_rd` high returns the current flags on `st_flags`, and the flags are cleared at that clock edge unless a new event arrives on the same edge.
- R5: Frames come out whole and in arrival order. Line bit k after the frame-start marker (k = 0..255) appears as output bit k of a frame.
- R6: With `s_fsync_dir` = 0, `s_fsync_oe` is 1 and `s_fsync_out` is high for exactly one system clock, on bit 255 of every output frame.
- R7: With `s_fsync_dir` = 1, `s_fsync_oe` and `s_fsync_out` are 0. A high on `s_fsync_in` sampled at an edge makes the next cycle bit 0 of a newly loaded output frame.
- R8: `s_mfsync` is high for one system clock, on bit 255 of the frame whose multiframe index is 1. The index counts 0..15 and advances at every output frame boundary.
- R9: In follow mode, a sampled `s_fsync_in` pulse with `s_mf_align` high sets the index of the new frame to 0. Without `s_mf_align`, the index advances as usual.
- R10: While reset is asserted and before the first system clock edge after its release, `st_flags`, `s_fsync_out` and `s_mfsync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| l_clk | input | 1 | Recovered line bit clock |
| l_data | input | 1 | Line serial payload |
| l_fstart | input | 1 | High with the first bit of each line frame |
| s_clk | input | 1 | System bit clock |
| s_fsync_dir | input | 1 | 0: generate frame sync, 1: follow frame sync |
| s_fsync_in | input | 1 | Frame sync from the terminal (follow mode) |
| s_mf_align | input | 1 | Clears the multiframe index together with `s_fsync_in` |
| st_rd | input | 1 | Status read strobe (system domain) |
| s_data | output | 1 | System serial payload |
| s_fsync_out | output | 1 | Generated frame sync pulse |
| s_fsync_oe | output | 1 | Drive enable for the frame sync pin |
| s_mfsync | output | 1 | Multiframe sync pulse |
| st_flags | output | 3 | {slip, empty, full} sticky flags |

## Verification
The line clock is first run faster than the system clock, then slower, so that both kinds of slip occur repeatedly. Each frame carries its own sequence number in bits 0..15 and a payload that is a function of that number. A buffer that dropped only part of a frame, repeated the wrong frame or slipped more than one frame would therefore show a corrupted payload or a wrong sequence step.

Every repeat must match an empty flag in the read taken during that frame, and over the whole run the number of full flags must equal the number of skips. A flag that was raised on the wrong event, lost when the clock domains were crossed, or not cleared by a read would break one of these counts. Follow mode is exercised with sync pulses that cut frames short, and one of those pulses carries the alignment input. A design that realigned one cycle late, kept the old frame after realigning, or ignored the alignment input would move the multiframe pulse away from the cycle the model expects.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;
    // Bit positions inside the status word
    localparam int ST_FULL  = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_SLIP  = 2;
    localparam int ST_W     = 3;
endpackage

// File: rtl/e1sb_sync.sv
module e1sb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/e1sb_wr.sv
// Line-domain side: assembles one frame, then commits it to a free slot or drops it.
module e1sb_wr #(
    parameter int FB    = 256,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       l_data,
    input  logic                       l_fstart,
    input  logic [$clog2(DEPTH):0]     rgray_s,
    output logic [$clog2(DEPTH):0]     wgray,
    output logic [DEPTH-1:0][FB-1:0]   store,
    output logic                       ovf_tgl
);
    localparam int BW = $clog2(FB);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][FB-1:0] mem;
        logic [FB-1:0]            sh;
        logic [BW-1:0]            bitc;
        logic                     act;
        logic [PW-1:0]            wbin;
        logic [PW-1:0]            wgray;
        logic                     tgl;
    } wr_t;

    wr_t           q, d;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] fill;
    logic [BW-1:0] pos;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
        d      = q;
        pos    = l_fstart ? '0 : q.bitc;
        d.sh[pos] = l_data;
        d.act  = q.act | l_fstart;
        d.bitc = (pos == BW'(FB-1)) ? '0 : pos + 1'b1;
        fill   = q.wbin - rbin_s;
        if (d.act && pos == BW'(FB-1)) begin
            if (fill == PW'(DEPTH)) begin
                d.tgl = ~q.tgl;
            end else begin
                d.mem[q.wbin[AW-1:0]] = d.sh;
                d.wbin = q.wbin + 1'b1;
            end
        end
        d.wgray = d.wbin ^ (d.wbin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wgray   = q.wgray;
    assign store   = q.mem;
    assign ovf_tgl = q.tgl;
endmodule

// File: rtl/e1sb_rd.sv
// System-domain side: frame timing, whole-frame load or repeat, sync pulses, sticky flags.
module e1sb_rd
    import e1sb_pkg::*;
#(
    parameter int FB    = 256,
    parameter int DEPTH = 2,
    parameter int MFN   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH):0]     wgray_s,
    input  logic [DEPTH-1:0][FB-1:0]   store,
    input  logic                       ovf_tgl_s,
    input  logic                       dir,
    input  logic                       fsync_in,
    input  logic                       mf_align,
    input  logic                       st_rd,
    output logic                       s_data,
    output logic                       fsync_out,
    output logic                       fsync_oe,
    output logic                       mfsync,
    output logic [$clog2(DEPTH):0]     rgray,
    output logic [ST_W-1:0]            flags,
    output logic [$clog2(FB)-1:0]      bit_pos,
    output logic [$clog2(MFN)-1:0]     mf_idx
);
    localparam int BW = $clog2(FB);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int MW = $clog2(MFN);

    typedef struct packed {
        logic [FB-1:0]   cur;
        logic [BW-1:0]   bitc;
        logic [MW-1:0]   mf;
        logic [PW-1:0]   rbin;
        logic [PW-1:0]   rgray;
        logic            tgl_seen;
        logic [ST_W-1:0] flags;
    } rd_t;

    rd_t           q, d;
    logic [PW-1:0] wbin_s;
    logic          at_last, realign, bnd, ovf_evt, und;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
        at_last = (q.bitc == BW'(FB-1));
        realign = dir & fsync_in;
        bnd     = at_last | realign;
        ovf_evt = ovf_tgl_s ^ q.tgl_seen;
        und     = 1'b0;
        d          = q;
        d.tgl_seen = ovf_tgl_s;
        if (bnd) begin
            d.bitc = '0;
            if (realign && mf_align)       d.mf = '0;
            else if (q.mf == MW'(MFN-1))   d.mf = '0;
            else                           d.mf = q.mf + 1'b1;
            if (wbin_s != q.rbin) begin
                d.cur  = store[q.rbin[AW-1:0]];
                d.rbin = q.rbin + 1'b1;
            end else begin
                und = 1'b1;
            end
        end else begin
            d.bitc = q.bitc + 1'b1;
        end
        d.rgray = d.rbin ^ (d.rbin >> 1);
        if (st_rd)         d.flags = '0;
        if (ovf_evt)       d.flags[ST_FULL]  = 1'b1;
        if (und)           d.flags[ST_EMPTY] = 1'b1;
        if (ovf_evt | und) d.flags[ST_SLIP]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign s_data    = q.cur[q.bitc];
    assign fsync_out = ~dir & at_last;
    assign fsync_oe  = ~dir;
    assign mfsync    = at_last & (q.mf == MW'(1));
    assign rgray     = q.rgray;
    assign flags     = q.flags;
    assign bit_pos   = q.bitc;
    assign mf_idx    = q.mf;
endmodule

// File: rtl/e1_slip_buffer.sv
module e1_slip_buffer #(
    parameter int FRAME_BITS   = 256,
    parameter int DEPTH_FRAMES = 2,
    parameter int MF_FRAMES    = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       rst_n,
    input  logic       l_clk,
    input  logic       l_data,
    input  logic       l_fstart,
    input  logic       s_clk,
    input  logic       s_fsync_dir,
    input  logic       s_fsync_in,
    input  logic       s_mf_align,
    input  logic       st_rd,
    output logic       s_data,
    output logic       s_fsync_out,
    output logic       s_fsync_oe,
    output logic       s_mfsync,
    output logic [2:0] st_flags
);
    localparam int AW = $clog2(DEPTH_FRAMES);
    localparam int PW = AW + 1;
    localparam int BW = $clog2(FRAME_BITS);
    localparam int MW = $clog2(MF_FRAMES);

    logic [PW-1:0]                         wgray, wgray_s, rgray, rgray_s;
    logic [DEPTH_FRAMES-1:0][FRAME_BITS-1:0] store;
    logic                                  ovf_tgl, ovf_tgl_s;
    logic [BW-1:0]                         rd_bit;
    logic [MW-1:0]                         rd_mf;

    e1sb_wr #(.FB(FRAME_BITS), .DEPTH(DEPTH_FRAMES)) u_wr (
        .clk(l_clk), .rst_n(rst_n), .l_data(l_data), .l_fstart(l_fstart),
        .rgray_s(rgray_s), .wgray(wgray), .store(store), .ovf_tgl(ovf_tgl)
    );

    e1sb_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(l_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    e1sb_sync #(.W(PW + 1), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(s_clk), .rst_n(rst_n), .d({ovf_tgl, wgray}), .q({ovf_tgl_s, wgray_s})
    );

    e1sb_rd #(.FB(FRAME_BITS), .DEPTH(DEPTH_FRAMES), .MFN(MF_FRAMES)) u_rd (
        .clk(s_clk), .rst_n(rst_n), .wgray_s(wgray_s), .store(store),
        .ovf_tgl_s(ovf_tgl_s), .dir(s_fsync_dir), .fsync_in(s_fsync_in),
        .mf_align(s_mf_align), .st_rd(st_rd), .s_data(s_data),
        .fsync_out(s_fsync_out), .fsync_oe(s_fsync_oe), .mfsync(s_mfsync),
        .rgray(rgray), .flags(st_flags), .bit_pos(rd_bit), .mf_idx(rd_mf)
    );
endmodule

// File: rtl/e1sb_checker.sv
module e1sb_checker #(
    parameter int FB = 256,
    parameter int BW = 8,
    parameter int MW = 4
) (
    input logic          s_clk,
    input logic          rst_n,
    input logic          s_fsync_dir,
    input logic          s_fsync_in,
    input logic          s_mf_align,
    input logic          s_fsync_out,
    input logic          s_mfsync,
    input logic          st_rd,
    input logic [2:0]    st_flags,
    input logic [BW-1:0] rd_bit,
    input logic [MW-1:0] rd_mf
);
    AST_EMPTY_AT_FRAME_START: assert property (@(posedge s_clk) disable iff (!rst_n)
        $rose(st_flags[1]) |-> rd_bit == '0); // R2
    AST_SLIP_HAS_CAUSE: assert property (@(posedge s_clk) disable iff (!rst_n)
        st_flags[2] |-> (st_flags[0] || st_flags[1])); // R3
    AST_EMPTY_STICKY: assert property (@(posedge s_clk) disable iff (!rst_n)
        (st_flags[1] && !st_rd) |=> st_flags[1]); // R4
    AST_EMPTY_CLEARED: assert property (@(posedge s_clk) disable iff (!rst_n)
        (st_rd && rd_bit != BW'(FB-1) && !(s_fsync_dir && s_fsync_in)) |=> !st_flags[1]); // R4
    AST_FSYNC_SINGLE: assert property (@(posedge s_clk) disable iff (!rst_n)
        s_fsync_out |=> (!s_fsync_out && rd_bit == '0)); // R6
    AST_REALIGN_NEXT: assert property (@(posedge s_clk) disable iff (!rst_n)
        (s_fsync_dir && s_fsync_in) |=> rd_bit == '0); // R7
    AST_MFSYNC_STEP: assert property (@(posedge s_clk) disable iff (!rst_n)
        (s_mfsync && !(s_fsync_dir && s_fsync_in && s_mf_align)) |=> (rd_bit == '0 && rd_mf == MW'(2))); // R8
    AST_MF_ALIGN: assert property (@(posedge s_clk) disable iff (!rst_n)
        (s_fsync_dir && s_fsync_in && s_mf_align) |=> rd_mf == '0); // R9
endmodule

bind e1_slip_buffer e1sb_checker #(.FB(FRAME_BITS), .BW(BW), .MW(MW)) u_chk (
    .s_clk(s_clk), .rst_n(rst_n), .s_fsync_dir(s_fsync_dir), .s_fsync_in(s_fsync_in),
    .s_mf_align(s_mf_align), .s_fsync_out(s_fsync_out), .s_mfsync(s_mfsync),
    .st_rd(st_rd), .st_flags(st_flags), .rd_bit(rd_bit), .rd_mf(rd_mf)
);

// File: tb/sim_e1_slip_buffer.sv
module sim_e1_slip_buffer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FB  = 256;
    localparam int MFN = 16;

    logic rst_n = 0, l_clk = 0, s_clk = 0, l_data = 0, l_fstart = 0;
    logic dir = 0, fin = 0, align = 0, st_rd = 0;
    logic s_data, fout, foe, mfs;
    logic [2:0] flags;
    real lper = 4.5;

    always #2.5 s_clk = ~s_clk;
    always #(lper / 2.0) l_clk = ~l_clk;

    e1_slip_buffer u0 (
        .rst_n(rst_n), .l_clk(l_clk), .l_data(l_data), .l_fstart(l_fstart),
        .s_clk(s_clk), .s_fsync_dir(dir), .s_fsync_in(fin), .s_mf_align(align),
        .st_rd(st_rd), .s_data(s_data), .s_fsync_out(fout), .s_fsync_oe(foe),
        .s_mfsync(mfs), .st_flags(flags)
    );

    int tests = 0, fails = 0;
    int m_bit = 0, m_mf = 0, nfr = 0, prev = 0, nskip = 0, nrep = 0, nfull = 0;
    int pc = 0, npulse = 0, lseq = 1, lbit = 0;
    bit started = 0, rd_done = 0, rd_empty = 0, last_had_rd = 1, done = 0, reported = 0;
    logic [FB-1:0] cap = '0;

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic logic pat(int seq, int i);
        if (i < 16) return seq[i];
        return ((seq * 31 + i * i) % 7) < 3;
    endfunction

    // line side stimulus: frames numbered from 1, sequence in bits 0..15
    always @(negedge l_clk) begin
        if (rst_n) begin
            l_fstart = (lbit == 0);
            l_data   = pat(lseq, lbit);
            if (lbit == FB - 1) begin
                lbit = 0;
                lseq++;
            end else lbit++;
        end
    end

    task automatic end_frame(int len);
        int seq, dlt, errs;
        seq = int'(cap[15:0]);
        if (len >= 16) begin
            if (!started) begin
                if (seq != 0) begin
                    started = 1;
                    chk("R5 first delivered frame", seq, 1);
                    prev = seq;
                end
            end else begin
                dlt = seq - prev;
                if (dlt == 0) begin
                    nrep++;
                    if (rd_done) chk("R2 repeat raises empty", rd_empty, 1);
                end else if (dlt == 1) begin
                    if (rd_done && last_had_rd) chk("R2 empty only on repeat", rd_empty, 0);
                end else begin
                    chk("R1 discard skips exactly one frame", dlt, 2);
                    nskip++;
                end
                if (len == FB) begin
                    errs = 0;
                    for (int i = 16; i < FB; i++) if (cap[i] !== pat(seq, i)) errs++;
                    chk("R5 payload intact", errs, 0);
                end
                prev = seq;
            end
        end
        last_had_rd = rd_done;
        rd_done = 0;
    endtask

    // system side reference model, compared every clock away from the edge
    always @(negedge s_clk) begin
        if (rst_n && !done) begin
            chk("R6/R7 fsync_out", fout, (!dir && m_bit == FB - 1));
            chk("R6/R7 fsync_oe", foe, !dir);
            chk("R8 mfsync", mfs, (m_bit == FB - 1 && m_mf == 1));
            chk("R3 slip with cause", flags[2], flags[0] | flags[1]);
            cap[m_bit] = s_data;
            if (m_bit == 128) begin
                rd_done  = 1;
                rd_empty = flags[1];
                nfull += int'(flags[0]);
            end
            if (m_bit == 129) chk("R4 empty cleared by read", flags[1], 0);
            // drive inputs for the coming edge
            dir = (nfr >= 110);
            if (dir) pc++;
            fin = dir && (pc % 612 == 611);
            if (fin) npulse++;
            align = fin && (npulse == 3);
            st_rd = (m_bit == 128);
            lper  = (nfr < 60) ? 4.5 : 5.6;
            // advance
            if (m_bit == FB - 1 || fin) begin
                end_frame(m_bit + 1);
                m_bit = 0;
                m_mf  = align ? 0 : (m_mf + 1) % MFN;
                nfr++;
            end else m_bit++;
            if (nfr >= 150) done = 1;
        end
    end

    initial begin
        repeat (10) @(posedge s_clk);
        @(negedge s_clk);
        chk("R10 reset flags", int'(flags), 0);
        chk("R10 reset fsync", fout, 0);
        chk("R10 reset mfsync", mfs, 0);
        @(posedge s_clk);
        #1 rst_n = 1;
        @(negedge s_clk);
        chk("R10 flags before first edge", int'(flags), 0);
        wait (done);
        @(negedge s_clk);
        chk("R1 discards occurred", int'(nskip > 0), 1);
        chk("R1 full flags match discards", nfull, nskip);
        chk("R2 repeats occurred", int'(nrep > 0), 1);
        chk("R9 aligned pulse issued", int'(npulse >= 3), 1);
        report();
    end

    initial begin
        #900000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule